// File: doc/BRIEF.md
# Dual-Role Eight-Pin I/O Port

This block is an eight-pin bidirectional port with two registers on a 16-bit memory-mapped bus. A direction register chooses which pins drive, and a data register holds the levels they drive. Every pin also has one fixed second role:
- a timer level on pin 7;
- interrupt and converter-trigger inputs on pins 6 and 5;
- bus wait, bus request and bus grant on pins 4 to 2;
- two strobe/clock outputs on pins 1 and 0.

An operating-mode input selects single-chip or expanded operation. In single-chip operation the three bus pins are ordinary general-purpose pins. In expanded operation they are given to the bus roles.

The block does not drive pads. It produces an output enable and an output level for each pin. It samples every pin through a two-stage synchroniser and passes the synchronised levels to the consumers of the alternate functions. The timer, interrupt logic, converter and bus controller are outside the block.

Top module: `altfunc_gpio_port`

## Requirements
- R1: After reset, the direction register holds 0x03 and data-register bits 7..2 hold 0. In single-chip mode pin_oe therefore reads 0x03 and pin_out[7:2] reads 0.
- R2: A bus write (bus_sel=1, bus_wr=1) to address 0xFE80 loads the direction register in the following cycle. A read of 0xFE80 always returns 0xFF.
- R3: On pins 7..2, when no alternate output claims the pin, a direction bit of 1 drives the data-register bit onto pin_out with pin_oe=1. A direction bit of 0 releases the pin (pin_oe=0). A write to 0xFE82 updates bits 7..2.
- R4: A read of 0xFE82 returns, for bits 7..2, the data-register bit where the direction bit is 1 and the synchronised pin level where it is 0. Bits 1..0 always return the synchronised pin level, and writes to those two bits have no effect.
- R5: Pins 1 and 0 never carry data-register values. Pin 1 drives estrobe and pin 0 drives sysclk_out, each enabled by direction bit 1 or bit 0 respectively.
- R6: While tmr_oe=1, pin 7 is driven (pin_oe[7]=1) with tmr_level, whatever the direction and data bits are.
- R7: With expanded_mode=1, pins 4 and 3 are never driven, and wait_lvl and busreq_lvl follow the synchronised levels of pins 4 and 3. Pin 2 is always driven with busack_n.
- R8: With expanded_mode=0, pins 4..2 behave as plain general-purpose pins, and wait_lvl and busreq_lvl are held at 1 (inactive).
- R9: irq_lvl[1] and adc_trig_lvl follow pin 6, and irq_lvl[0] follows pin 5. Each is delayed by two clock edges, whatever the direction setting.
- R10: Writes to any other address change neither register, and a read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expanded_mode | input | 1 | 1 = expanded operation, 0 = single-chip |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |
| tmr_oe | input | 1 | Timer claims pin 7 |
| tmr_level | input | 1 | Timer output level |
| busack_n | input | 1 | Bus grant level for pin 2 |
| estrobe | input | 1 | Strobe level for pin 1 |
| sysclk_out | input | 1 | Clock level for pin 0 |
| irq_lvl | output | 2 | Synchronised interrupt pin levels (pins 6, 5) |
| adc_trig_lvl | output | 1 | Synchronised converter trigger level (pin 6) |
| wait_lvl | output | 1 | Synchronised bus wait level (pin 4), or 1 |
| busreq_lvl | output | 1 | Synchronised bus request level (pin 3), or 1 |

## Verification
Two functions can act on pin 7 in the same cycle: a bus write to the data register and a timer claim of the pin. The bench makes both happen together. It sets direction bit 7, holds tmr_oe high, and in that same cycle writes a data byte whose bit 7 differs from tmr_level. It then expects pin 7 to show the timer level. Once tmr_oe is dropped it expects the level that was written, which shows the write was kept while the override held. A read of 0xFE82 during the override must also return the written bit.

// File: rtl/altport_pkg.sv
package altport_pkg;
  localparam int ADDR_W   = 16;
  localparam int PORT_W   = 8;
  localparam int N_STROBE = 2;   // low pins that are strobe/clock only
  localparam logic [ADDR_W-1:0] DIR_ADDR = 16'hFE80;
  localparam logic [ADDR_W-1:0] DAT_ADDR = 16'hFE82;
  localparam logic [PORT_W-1:0] DIR_RST  = 8'h03;
  localparam logic [PORT_W-1:0] DIR_RDBK = 8'hFF;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
  import altport_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [PORT_W-1:0]          wdata,
  input  logic [PORT_W-1:0]          pin_sync,
  output logic [PORT_W-1:0]          dir_q,
  output logic [PORT_W-1:N_STROBE]   dat_q,
  output logic [PORT_W-1:0]          rdata
);
  logic                     wr_dir, wr_dat;
  logic [PORT_W-1:0]        dir_d;
  logic [PORT_W-1:N_STROBE] dat_d;
  logic [PORT_W-1:0]        dat_view;

  assign wr_dir = sel & wr & (addr == DIR_ADDR);
  assign wr_dat = sel & wr & (addr == DAT_ADDR);

  always_comb begin
    dir_d = wr_dir ? wdata : dir_q;
    dat_d = wr_dat ? wdata[PORT_W-1:N_STROBE] : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
      dat_q <= '0;
    end else begin
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_view
    if (i < N_STROBE) begin : g_ro
      assign dat_view[i] = pin_sync[i];
    end else begin : g_rw
      assign dat_view[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
    end
  end

  always_comb begin
    case (addr)
      DIR_ADDR: rdata = DIR_RDBK;
      DAT_ADDR: rdata = dat_view;
      default:  rdata = '0;
    endcase
  end

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata));
  p_dat_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> dat_q == $past(wdata[PORT_W-1:N_STROBE]));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(dir_q) && $stable(dat_q));
endmodule

// File: rtl/port_pinmux.sv
module port_pinmux
  import altport_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     expanded_mode,
  input  logic [PORT_W-1:0]        dir_q,
  input  logic [PORT_W-1:N_STROBE] dat_q,
  input  logic [6:3]               alt_in,
  input  logic                     tmr_oe,
  input  logic                     tmr_level,
  input  logic                     busack_n,
  input  logic                     estrobe,
  input  logic                     sysclk_out,
  output logic [PORT_W-1:0]        pin_oe,
  output logic [PORT_W-1:0]        pin_out,
  output logic [1:0]               irq_lvl,
  output logic                     adc_trig_lvl,
  output logic                     wait_lvl,
  output logic                     busreq_lvl
);
  always_comb begin
    pin_oe  = '0;
    pin_out = '0;
    for (int i = N_STROBE; i < PORT_W; i++) begin
      pin_oe[i]  = dir_q[i];
      pin_out[i] = dat_q[i];
    end
    if (tmr_oe) begin
      pin_oe[7]  = 1'b1;
      pin_out[7] = tmr_level;
    end
    if (expanded_mode) begin
      pin_oe[4]  = 1'b0;
      pin_oe[3]  = 1'b0;
      pin_oe[2]  = 1'b1;
      pin_out[2] = busack_n;
    end
    pin_oe[1]  = dir_q[1];
    pin_out[1] = estrobe;
    pin_oe[0]  = dir_q[0];
    pin_out[0] = sysclk_out;
  end

  assign irq_lvl      = {alt_in[6], alt_in[5]};
  assign adc_trig_lvl = alt_in[6];
  assign wait_lvl     = expanded_mode ? alt_in[4] : 1'b1;
  assign busreq_lvl   = expanded_mode ? alt_in[3] : 1'b1;

  p_tmr_override_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_oe |-> pin_oe[7] && (pin_out[7] == tmr_level));
  p_bus_inputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expanded_mode |-> !pin_oe[4] && !pin_oe[3] && pin_oe[2]);
  p_bus_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !expanded_mode |-> wait_lvl && busreq_lvl);
  p_strobe_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out[1] == estrobe) && (pin_out[0] == sysclk_out));
endmodule

// File: rtl/altfunc_gpio_port.sv
module altfunc_gpio_port
  import altport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expanded_mode,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [15:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_oe,
  output logic [7:0]        pin_out,
  input  logic              tmr_oe,
  input  logic              tmr_level,
  input  logic              busack_n,
  input  logic              estrobe,
  input  logic              sysclk_out,
  output logic [1:0]        irq_lvl,
  output logic              adc_trig_lvl,
  output logic              wait_lvl,
  output logic              busreq_lvl
);
  logic [1:0]               rst_pipe;
  logic                     core_rst_n;
  logic [PORT_W-1:0]        pin_sync;
  logic [PORT_W-1:0]        dir_q;
  logic [PORT_W-1:N_STROBE] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  port_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(core_rst_n), .d(pin_in), .q(pin_sync));

  port_regs i_regs (
    .clk(clk), .rst_n(core_rst_n), .sel(bus_sel), .wr(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .pin_sync(pin_sync),
    .dir_q(dir_q), .dat_q(dat_q), .rdata(bus_rdata));

  port_pinmux i_mux (
    .clk(clk), .rst_n(core_rst_n), .expanded_mode(expanded_mode),
    .dir_q(dir_q), .dat_q(dat_q), .alt_in(pin_sync[6:3]),
    .tmr_oe(tmr_oe), .tmr_level(tmr_level), .busack_n(busack_n),
    .estrobe(estrobe), .sysclk_out(sysclk_out),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq_lvl(irq_lvl),
    .adc_trig_lvl(adc_trig_lvl), .wait_lvl(wait_lvl),
    .busreq_lvl(busreq_lvl));
endmodule

// File: tb/test_altfunc_gpio_port.sv
`timescale 1ns/1ps
module test_altfunc_gpio_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic expanded_mode = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [7:0]  pin_in = 8'hA5, pin_oe, pin_out;
  logic tmr_oe = 1'b0, tmr_level = 1'b0, busack_n = 1'b1;
  logic estrobe = 1'b1, sysclk_out = 1'b0;
  logic [1:0] irq_lvl;
  logic adc_trig_lvl, wait_lvl, busreq_lvl;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  altfunc_gpio_port i_altfunc_gpio_port (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    check("R1 oe", pin_oe, 8'h03);
    check("R1 out", pin_out & 8'hFC, 8'h00);
    bus_read(16'hFE82, r);
    check("R1 data read", r, 8'hA5);
  endtask

  task automatic t_dir;
    logic [7:0] r;
    bus_write(16'hFE80, 8'h3C);
    check("R2 dir load", pin_oe, 8'h3C);
    bus_read(16'hFE80, r);
    check("R2 dir readback", r, 8'hFF);
    bus_write(16'hFE84, 8'hFF);
    check("R10 foreign write", pin_oe, 8'h3C);
    bus_read(16'hFE84, r);
    check("R10 foreign read", r, 8'h00);
  endtask

  task automatic t_gpio_out;
    bus_write(16'hFE80, 8'hFC);
    bus_write(16'hFE82, 8'hA4);
    check("R3 out A4", pin_out & 8'hFC, 8'hA4);
    bus_write(16'hFE82, 8'h58);
    check("R3 out 58", pin_out & 8'hFC, 8'h58);
    bus_write(16'hFE80, 8'h0C);
    check("R3 release", pin_oe, 8'h0C);
  endtask

  task automatic t_dat_read;
    logic [7:0] r;
    bus_write(16'hFE80, 8'hF0);
    bus_write(16'hFE82, 8'hFF);
    set_pins(8'h0E);
    bus_read(16'hFE82, r);
    check("R4 mixed read", r, 8'hFE);
    bus_write(16'hFE82, 8'h03);
    set_pins(8'h01);
    bus_read(16'hFE82, r);
    check("R4 low bits pin", r, 8'h01);
  endtask

  task automatic t_strobe;
    bus_write(16'hFE82, 8'h03);
    bus_write(16'hFE80, 8'h03);
    estrobe = 1'b0; sysclk_out = 1'b1;
    #1 check("R5 strobe pins", {6'b0, pin_out[1:0]}, 8'h01);
    check("R5 strobe oe", pin_oe, 8'h03);
    bus_write(16'hFE80, 8'h00);
    check("R5 strobe off", {6'b0, pin_oe[1:0]}, 8'h00);
    estrobe = 1'b1; sysclk_out = 1'b0;
  endtask

  task automatic t_timer;
    logic [7:0] r;
    bus_write(16'hFE80, 8'h00);
    @(negedge clk);
    tmr_oe = 1'b1; tmr_level = 1'b0;
    #1 check("R6 claim oe", {7'b0, pin_oe[7]}, 8'h01);
    bus_write(16'hFE80, 8'h80);
    bus_write(16'hFE82, 8'h80);
    check("R6 override", {7'b0, pin_out[7]}, 8'h00);
    bus_read(16'hFE82, r);
    check("R6 write kept", {7'b0, r[7]}, 8'h01);
    @(negedge clk);
    tmr_oe = 1'b0;
    #1 check("R6 release", {7'b0, pin_out[7]}, 8'h01);
  endtask

  task automatic t_expanded;
    bus_write(16'hFE80, 8'h1C);
    bus_write(16'hFE82, 8'h1C);
    @(negedge clk);
    expanded_mode = 1'b1; busack_n = 1'b0;
    set_pins(8'h10);
    check("R7 oe", pin_oe & 8'h1C, 8'h04);
    check("R7 ack", {7'b0, pin_out[2]}, 8'h00);
    check("R7 wait/req", {6'b0, wait_lvl, busreq_lvl}, 8'h02);
    set_pins(8'h08);
    check("R7 wait/req 2", {6'b0, wait_lvl, busreq_lvl}, 8'h01);
  endtask

  task automatic t_single;
    @(negedge clk);
    expanded_mode = 1'b0; busack_n = 1'b1;
    set_pins(8'h00);
    check("R8 oe", pin_oe & 8'h1C, 8'h1C);
    check("R8 out", pin_out & 8'h1C, 8'h1C);
    check("R8 idle", {6'b0, wait_lvl, busreq_lvl}, 8'h03);
  endtask

  task automatic t_alt_in;
    bus_write(16'hFE80, 8'h60);
    bus_write(16'hFE82, 8'h00);
    @(negedge clk);
    pin_in = 8'h40;
    @(negedge clk);
    check("R9 one edge", {5'b0, irq_lvl, adc_trig_lvl}, 8'h00);
    @(negedge clk);
    check("R9 two edges", {5'b0, irq_lvl, adc_trig_lvl}, 8'h05);
    set_pins(8'h20);
    check("R9 pin5", {5'b0, irq_lvl, adc_trig_lvl}, 8'h02);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir();
    t_gpio_out();
    t_dat_read();
    t_strobe();
    t_timer();
    t_expanded();
    t_single();
    t_alt_in();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule